// File: doc/BRIEF.md
# Vector Strip-Mining Length Sequencer

This block turns a loop over `n` elements into a series of vector chunks, each no longer than the vector register capacity `MVL`. The first chunk carries the leftover `n mod MVL` elements. Every chunk after it is a full `MVL`. There are `n / MVL + 1` chunks in total.

For each chunk the block offers its length and its starting element index on a valid/ready handshake. When the consumer accepts that handshake, the block captures a per-element write mask. It then streams one beat per element. Each beat carries a strided byte address and a write-enable taken from the mask.

A job is launched with a one-cycle `start` pulse. The pulse carries the element count, the stride in elements and the base byte address. The block pulses `chunk_done` as each chunk finishes and pulses `done` together with the final one.

Top module: `vec_strip_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `chunk_valid`, `elem_valid`, `chunk_done` and `done` are all 0.
- R2: The first chunk offered after `start` has `chunk_len = n mod MVL` and `chunk_base = 0`.
- R3: Every chunk after the first has `chunk_len = MVL`, and a job with `n` elements offers exactly `n / MVL + 1` chunks (integer division).
- R4: The `chunk_base` of each chunk equals the previous chunk's `chunk_base` plus the previous chunk's length.
- R5: The element beat with index `i` (0-based) in a chunk has `elem_addr = base_addr + (chunk_base + i) * stride * 2^ESIZE_LOG2`, taken modulo `2^ADDR_W`.
- R6: `elem_we` of element `i` equals bit `i` of the `chunk_mask` value present in the cycle its chunk handshake was accepted. Bit 0 belongs to the first element; 1 means write back and 0 means suppress.
- R7: A chunk of length 0 is still offered on the chunk handshake with `chunk_len = 0`, and it produces no element beats.
- R8: While `elem_valid` is 1 and `elem_ready` is 0, `elem_valid`, `elem_addr` and `elem_we` hold their values into the next cycle.
- R9: `chunk_done` is a one-cycle pulse that follows the last element beat of each chunk, or the accepted handshake of a zero-length chunk. `done` pulses in the same cycle as the `chunk_done` of the final chunk, and never otherwise.
- R10: A `start` pulse while `busy` is 1 is ignored: the running job's chunks and addresses are unchanged, and no further job follows it.
- R11: `n = 0` completes with one zero-length chunk, followed at once by `chunk_done` and `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a job (ignored while busy) |
| n_elems | input | N_W | Total element count of the loop |
| stride | input | STRIDE_W | Distance between consecutive elements, in elements |
| base_addr | input | ADDR_W | Byte address of element 0 |
| chunk_mask | input | MVL | Write mask sampled when a chunk is accepted |
| busy | output | 1 | A job is in progress |
| chunk_valid | output | 1 | Chunk length and base are offered |
| chunk_ready | input | 1 | Consumer accepts the chunk |
| chunk_len | output | LEN_W | Element count of the offered chunk |
| chunk_base | output | N_W | Index of the chunk's first element |
| elem_valid | output | 1 | An element beat is offered |
| elem_ready | input | 1 | Consumer accepts the element beat |
| elem_addr | output | ADDR_W | Byte address of the element |
| elem_we | output | 1 | Write-back enable of the element |
| chunk_done | output | 1 | Pulse after a chunk finishes |
| done | output | 1 | Pulse when the final chunk finishes |

## Verification
The bench builds the block with `MVL = 8`, a 16-bit address, a 12-bit count and 4-byte elements. With these values a loop of a few dozen elements spans several full chunks and a leading remainder. Counts that are exact multiples of 8 bring the zero-length first chunk within reach. A large stride from a base near the top of the address space makes the addresses wrap modulo 2^16. Stalling both ready inputs on a fixed pattern exposes the hold behaviour, and a second `start` is injected in the middle of a job.

// File: rtl/vec_strip_pkg.sv
package vec_strip_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_OFFER = 2'd1,
    SQ_BEAT  = 2'd2,
    SQ_CLOSE = 2'd3
  } sq_state_t;
endpackage

// File: rtl/vec_strip_chunker.sv
module vec_strip_chunker #(
  parameter int MVL   = 64,
  parameter int N_W   = 16,
  parameter int LEN_W = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N_W-1:0]   n_in,
  input  logic             advance,
  output logic [LEN_W-1:0] len,
  output logic [N_W-1:0]   base,
  output logic             last
);
  localparam logic [N_W-1:0]   MVL_N = N_W'(MVL);
  localparam logic [LEN_W-1:0] FULL  = LEN_W'(MVL);

  logic [N_W-1:0] full_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      len       <= '0;
      base      <= '0;
      full_left <= '0;
    end else if (load) begin
      len       <= LEN_W'(n_in % MVL_N);
      base      <= '0;
      full_left <= n_in / MVL_N;
    end else if (advance) begin
      base      <= base + N_W'(len);
      len       <= FULL;
      full_left <= full_left - 1'b1;
    end
  end

  assign last = (full_left == '0);

  // R3
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> (len == FULL));
endmodule

// File: rtl/vec_strip_elemgen.sv
module vec_strip_elemgen #(
  parameter int MVL        = 64,
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int ESIZE_LOG2 = 2,
  parameter int LEN_W      = $clog2(MVL + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_job,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                take_chunk,
  input  logic [MVL-1:0]      mask_in,
  input  logic                beat,
  output logic [ADDR_W-1:0]   addr,
  output logic [LEN_W-1:0]    idx,
  output logic                we
);
  localparam int IDX_W = $clog2(MVL);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [ADDR_W-1:0] step_r;
  logic [MVL-1:0]    mask_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      step_r <= '0;
      mask_r <= '0;
      idx    <= '0;
    end else begin
      if (load_job) begin
        addr   <= base_addr;
        step_r <= ADDR_W'(stride) << ESIZE_LOG2;
      end else if (beat) begin
        addr <= addr + step_r;
      end
      if (take_chunk) begin
        mask_r <= mask_in;
        idx    <= '0;
      end else if (beat) begin
        idx <= idx + ONE;
      end
    end
  end

  assign we = mask_r[idx[IDX_W-1:0]];

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (beat && !load_job) |=> (addr == $past(addr) + step_r));
endmodule

// File: rtl/vec_strip_seq.sv
module vec_strip_seq
  import vec_strip_pkg::*;
#(
  parameter int MVL        = 64,
  parameter int N_W        = 16,
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 16,
  parameter int ESIZE_LOG2 = 2,
  parameter int LEN_W      = $clog2(MVL + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [N_W-1:0]      n_elems,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [MVL-1:0]      chunk_mask,
  output logic                busy,
  output logic                chunk_valid,
  input  logic                chunk_ready,
  output logic [LEN_W-1:0]    chunk_len,
  output logic [N_W-1:0]      chunk_base,
  output logic                elem_valid,
  input  logic                elem_ready,
  output logic [ADDR_W-1:0]   elem_addr,
  output logic                elem_we,
  output logic                chunk_done,
  output logic                done
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  sq_state_t state, state_nx;
  logic load, take, beat, advance, last;
  logic [LEN_W-1:0] idx;

  assign load    = (state == SQ_IDLE) && start;
  assign take    = (state == SQ_OFFER) && chunk_ready;
  assign beat    = (state == SQ_BEAT) && elem_ready;
  assign advance = (state == SQ_CLOSE) && !last;

  always_comb begin
    state_nx = state;
    case (state)
      SQ_IDLE:  if (start) state_nx = SQ_OFFER;
      SQ_OFFER: if (chunk_ready) state_nx = (chunk_len == '0) ? SQ_CLOSE : SQ_BEAT;
      SQ_BEAT:  if (elem_ready && (idx + ONE == chunk_len)) state_nx = SQ_CLOSE;
      SQ_CLOSE: state_nx = last ? SQ_IDLE : SQ_OFFER;
      default:  state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SQ_IDLE;
    else     state <= state_nx;
  end

  vec_strip_chunker #(.MVL(MVL), .N_W(N_W), .LEN_W(LEN_W)) u_chunker (
    .clk(clk), .rst(rst), .load(load), .n_in(n_elems), .advance(advance),
    .len(chunk_len), .base(chunk_base), .last(last)
  );

  vec_strip_elemgen #(.MVL(MVL), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W),
                      .ESIZE_LOG2(ESIZE_LOG2), .LEN_W(LEN_W)) u_elemgen (
    .clk(clk), .rst(rst), .load_job(load), .base_addr(base_addr), .stride(stride),
    .take_chunk(take), .mask_in(chunk_mask), .beat(beat),
    .addr(elem_addr), .idx(idx), .we(elem_we)
  );

  assign busy        = (state != SQ_IDLE);
  assign chunk_valid = (state == SQ_OFFER);
  assign elem_valid  = (state == SQ_BEAT);
  assign chunk_done  = (state == SQ_CLOSE);
  assign done        = (state == SQ_CLOSE) && last;

  // R8
  elem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && !elem_ready) |=> (elem_valid && $stable(elem_addr) && $stable(elem_we)));
  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    elem_valid |-> (chunk_len != '0));
  // R9
  done_pair_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> chunk_done);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    chunk_done |=> !chunk_done);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> busy);
endmodule

// File: tb/tb_vec_strip_seq.sv
module tb_vec_strip_seq;
  localparam int MVL = 8, N_W = 12, ADDR_W = 16, STRIDE_W = 12, ESZ = 2;
  localparam int LEN_W = $clog2(MVL + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0;
  logic [N_W-1:0] n_elems = '0;
  logic [STRIDE_W-1:0] stride = '0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [MVL-1:0] chunk_mask = '0;
  logic chunk_ready = 1'b0, elem_ready = 1'b0;
  logic busy, chunk_valid, elem_valid, elem_we, chunk_done, done;
  logic [LEN_W-1:0] chunk_len;
  logic [N_W-1:0] chunk_base;
  logic [ADDR_W-1:0] elem_addr;

  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  vec_strip_seq #(.MVL(MVL), .N_W(N_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W),
                  .ESIZE_LOG2(ESZ)) dut (
    .clk(clk), .rst(rst), .start(start), .n_elems(n_elems), .stride(stride),
    .base_addr(base_addr), .chunk_mask(chunk_mask), .busy(busy),
    .chunk_valid(chunk_valid), .chunk_ready(chunk_ready), .chunk_len(chunk_len),
    .chunk_base(chunk_base), .elem_valid(elem_valid), .elem_ready(elem_ready),
    .elem_addr(elem_addr), .elem_we(elem_we), .chunk_done(chunk_done), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [MVL-1:0] mask_for(input int c);
    return MVL'(8'hA5 ^ (c * 37));
  endfunction

  // mode 0: readies always high; mode 1: stalls on a fixed pattern
  task automatic run_job(input int n, input int strd, input int base, input int mode,
                         input bit inject);
    int cnum = 0, eidx = 0, exp_len = 0, exp_base = 0, ndone = 0;
    int exp_chunks = n / MVL + 1;
    logic [MVL-1:0] cur_mask = '0;
    bit in_chunk = 0, hold_pend = 0, finished = 0;
    logic [ADDR_W-1:0] hold_addr = '0;
    logic hold_we = 1'b0;
    @(negedge clk);
    n_elems = N_W'(n); stride = STRIDE_W'(strd); base_addr = ADDR_W'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 4000 && !finished; cyc++) begin
      if (cyc > 0) @(negedge clk);
      chunk_ready = (mode == 0) ? 1'b1 : (cyc % 3 == 0);
      elem_ready  = (mode == 0) ? 1'b1 : (cyc % 2 == 1);
      chunk_mask  = mask_for(cnum);
      start = inject && (cyc == 4);
      if (start) begin n_elems = 3; stride = 1; base_addr = 0; end
      if (hold_pend) begin
        chk(elem_valid && elem_addr == hold_addr && elem_we == hold_we,
            "R8 hold", int'(elem_addr), int'(hold_addr));
        hold_pend = 0;
      end
      if (chunk_valid && chunk_ready) begin
        exp_len  = (cnum == 0) ? n % MVL : MVL;
        exp_base = (cnum == 0) ? 0 : (n % MVL) + (cnum - 1) * MVL;
        if (cnum == 0) chk(chunk_len == LEN_W'(exp_len), "R2 first len", int'(chunk_len), exp_len);
        else           chk(chunk_len == LEN_W'(exp_len), "R3 full len", int'(chunk_len), exp_len);
        chk(chunk_base == N_W'(exp_base), "R4 chunk base", int'(chunk_base), exp_base);
        chk(cnum < exp_chunks, "R3 chunk count bound", cnum, exp_chunks);
        cur_mask = chunk_mask; eidx = 0; cnum++; in_chunk = 1;
      end
      if (elem_valid) begin
        logic [ADDR_W-1:0] ea;
        ea = ADDR_W'(base) + ADDR_W'((exp_base + eidx) * strd * (1 << ESZ));
        if (elem_ready) begin
          chk(elem_addr == ea, "R5 addr", int'(elem_addr), int'(ea));
          chk(elem_we == cur_mask[eidx], "R6 mask", int'(elem_we), int'(cur_mask[eidx]));
          chk(exp_len != 0, "R7 no beat in empty chunk", exp_len, 1);
          eidx++;
        end else begin
          hold_pend = 1; hold_addr = elem_addr; hold_we = elem_we;
        end
      end
      if (chunk_done) begin
        chk(in_chunk && eidx == exp_len, "R9 chunk_done after last beat", eidx, exp_len);
        in_chunk = 0;
        if (done) begin
          chk(cnum == exp_chunks, "R3 total chunks", cnum, exp_chunks);
          ndone++;
          finished = 1;
        end else begin
          chk(cnum < exp_chunks, "R9 done withheld", cnum, exp_chunks);
        end
      end else begin
        chk(!done, "R9 done only with chunk_done", int'(done), 0);
      end
    end
    start = 1'b0;
    chk(finished, "watchdog job end", int'(finished), 1);
    chk(ndone == 1, "R9 one done", ndone, 1);
    repeat (3) @(negedge clk);
    chk(!busy && !chunk_valid, "R10 idle after job", int'(busy), 0);
  endtask

  task automatic test_reset();
    chk(!busy && !chunk_valid && !elem_valid, "R1 reset outputs", int'(busy), 0);
    chk(!chunk_done && !done, "R1 reset pulses", int'(done), 0);
  endtask

  task automatic test_zero();
    // R11: n = 0, chunk of length 0 then chunk_done+done in the next cycle
    @(negedge clk);
    n_elems = 0; stride = 1; base_addr = 16'h40; start = 1'b1;
    chunk_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(chunk_valid && chunk_len == 0 && chunk_base == 0, "R11 zero chunk", int'(chunk_len), 0);
    @(negedge clk);
    chk(chunk_done && done && !elem_valid, "R11 immediate done", int'(done), 1);
    @(negedge clk);
    chk(!busy, "R11 idle", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_job(19, 3, 16'h100, 0, 0);      // R2 R3 R4: lengths 3,8,8
    run_job(16, 5, 16'h020, 1, 0);      // R7: exact multiple, empty first chunk, stalls
    test_zero();                        // R11
    run_job(5, 1, 16'h000, 1, 0);       // single partial chunk with stalls
    run_job(30, 12'h7FF, 16'hFF00, 0, 0); // R5 wraparound
    run_job(11, 2, 16'h300, 1, 1);      // R10 start while busy
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule